// File: doc/BRIEF.md
# Fractional-N Divide Ratio Sequencer

This block produces, once per phase-detector reference cycle, the integer division ratio that a multi-modulus feedback divider should use next. It is programmed with a 9-bit integer index, to which a fixed bias of 32 is added, and a signed fractional dividend. That dividend is an offset of about -0.5 to +0.5 divide steps around the rounded integer. A first-order signed accumulator dithers the ratio between base-1, base and base+1, so that the long-run average equals the index plus 32 plus the fraction.

The fraction has two resolutions. In wide mode it is 18 bits, built from a 10-bit upper part and an 8-bit lower part. In narrow mode it is 10 bits, held in the upper part alone. An integer-only mode turns the dithering off. New values go into shadow registers and are committed together. In the fractional modes the commit happens on the upper-part write. In integer mode it happens on the index write. A signed modulation offset is added to the committed dividend on every reference strobe, which allows direct frequency modulation without touching the channel registers.

Top module: `fracn_seq`

## Requirements
- R1: After reset the ratio output, the shadow registers, the committed values and the accumulator are all zero.
- R2: In integer mode (`modeInt`=1) each `refStrobe` yields ratio = index + 32 with no dithering. An index write takes effect on the next strobe, and a dividend write has no effect. Index 0 gives 32 and index 511 gives 543.
- R3: In wide mode (`modeInt`=0, `modeWide`=1) the dividend is the 18-bit two's complement value {upper[9:0], lower[7:0]}. It represents dividend/2^18 of a divide step.
- R4: In the fractional modes, writing the index or the lower part leaves the ratio unchanged until the upper part is written. That write commits the shadow index together with the full dividend.
- R5: In narrow mode (`modeWide`=0) the dividend is the 10-bit two's complement upper part alone, worth dividend/2^10 of a step. The lower register is ignored.
- R6: Starting from a cleared accumulator, a running sum that reaches +0.5 step emits base+1 and subtracts one step. A running sum that falls below -0.5 step emits base-1 and adds one step. With +0.25 the ratios are base, base+1, base, base. With -0.25 they are base, base, base-1, base.
- R7: `modOffset` is a 12-bit signed value in units of the active fraction LSB (2^-18 in wide mode, 2^-10 in narrow mode). It is added to the committed dividend on every strobe.
- R8: Dividend plus offset may reach ±0.5625 step. The ratio average over N strobes stays exact: from a cleared accumulator, 16 strobes at +0.5625 give 16·base+9.
- R9: Any change of `modeInt` or `modeWide` clears the accumulator.
- R10: The ratio output is registered. It changes only on the clock edge that samples `refStrobe` high, and holds otherwise.
- R11: In the fractional modes each emitted ratio lies within base-1..base+1 of the committed base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeInt | input | 1 | 1 = integer-only mode |
| modeWide | input | 1 | 1 = 18-bit fraction, 0 = 10-bit fraction |
| idxWr | input | 1 | Write strobe for the index register |
| idxData | input | 9 | Integer index (ratio minus 32) |
| fracLoWr | input | 1 | Write strobe for the dividend lower part |
| fracLoData | input | 8 | Dividend lower 8 bits (wide mode) |
| fracHiWr | input | 1 | Write strobe for the dividend upper part (commit) |
| fracHiData | input | 10 | Dividend upper 10 bits |
| modOffset | input | 12 | Signed modulation offset, active-LSB units |
| refStrobe | input | 1 | One pulse per reference cycle |
| ratio | output | 10 | Instantaneous integer division ratio |

## Verification
A wrong accumulator value does not show up as a wrong average at once. It shows as a carry or borrow in the wrong strobe, within the first one to four strobes after a clear. The bench therefore compares exact per-strobe sequences starting from a known cleared state. A wrong committed index or dividend shows on the very next strobe as a shifted base, or over a few strobes as a wrong sum. The bench checks those sums against closed-form values. Staging faults show as a ratio that moves before the upper-part write, and the bench checks for this with a strobe placed between the writes.

// File: rtl/fracn_seq_pkg.sv
package fracn_seq_pkg;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic ldIdx;       // capture index into shadow
    logic ldLo;        // capture lower dividend into shadow
    logic commitInt;   // integer mode: index goes live now
    logic commitFrac;  // fractional mode: shadow + upper part go live
    logic narrow;      // 10-bit fraction resolution selected
    logic intMode;     // integer-only operation
    logic clearAcc;    // mode changed: zero the accumulator
    logic step;        // reference cycle: produce next ratio
  } seqCtl_t;

endpackage

// File: rtl/fracn_seq_ctrl.sv
module fracn_seq_ctrl
  import fracn_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    modeInt,
  input  logic    modeWide,
  input  logic    idxWr,
  input  logic    fracLoWr,
  input  logic    fracHiWr,
  input  logic    refStrobe,
  output seqCtl_t ctl
);

  logic prevInt;
  logic prevWide;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevInt  <= 1'b0;
      prevWide <= 1'b0;
    end else begin
      prevInt  <= modeInt;
      prevWide <= modeWide;
    end
  end

  always_comb begin
    ctl.ldIdx      = idxWr;
    ctl.ldLo       = fracLoWr;
    ctl.commitInt  = idxWr && modeInt;
    ctl.commitFrac = fracHiWr && !modeInt;
    ctl.narrow     = !modeWide;
    ctl.intMode    = modeInt;
    ctl.clearAcc   = (modeInt != prevInt) || (modeWide != prevWide);
    ctl.step       = refStrobe;
  end

endmodule

// File: rtl/fracn_seq_dp.sv
module fracn_seq_dp
  import fracn_seq_pkg::*;
#(
  parameter int IDX_W = 9,
  parameter int HI_W  = 10,
  parameter int LO_W  = 8,
  parameter int MOD_W = 12,
  parameter int BIAS  = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCtl_t          ctl,
  input  logic [IDX_W-1:0] idxData,
  input  logic [LO_W-1:0]  loData,
  input  logic [HI_W-1:0]  hiData,
  input  logic [MOD_W-1:0] modOffset,
  output logic [IDX_W:0]   ratio
);

  localparam int FRAC_W  = HI_W + LO_W;
  localparam int SUM_W   = FRAC_W + 4;
  localparam int RATIO_W = IDX_W + 1;
  localparam int HALF_I  = 1 << (FRAC_W - 1);
  localparam int FULL_I  = 1 << FRAC_W;
  localparam int LIMIT_I = 9 * (1 << (FRAC_W - 4));   // 0.5625 step

  localparam logic signed [SUM_W-1:0] HALF_S  = SUM_W'(HALF_I);
  localparam logic signed [SUM_W-1:0] FULL_S  = SUM_W'(FULL_I);
  localparam logic signed [SUM_W-1:0] LIMIT_S = SUM_W'(LIMIT_I);

  // Shadow and live state
  logic [IDX_W-1:0]         shIdx;
  logic [LO_W-1:0]          shLo;
  logic [IDX_W-1:0]         actIdx;
  logic signed [FRAC_W-1:0] actFrac;   // always in wide-LSB units
  logic signed [FRAC_W-1:0] accQ;
  logic [RATIO_W-1:0]       ratioQ;

  // Next-state datapath
  logic signed [MOD_W-1:0]  modS;
  logic signed [SUM_W-1:0]  modExt;
  logic signed [SUM_W-1:0]  fracSum;
  logic signed [SUM_W-1:0]  accSum;
  logic signed [SUM_W-1:0]  accWrap;
  logic                     carryUp;
  logic                     carryDn;
  logic [RATIO_W-1:0]       base;
  logic [RATIO_W-1:0]       ratioNext;
  logic signed [FRAC_W-1:0] fracCommit;

  always_comb begin
    modS    = $signed(modOffset);
    modExt  = ctl.narrow ? (SUM_W'(modS) <<< LO_W) : SUM_W'(modS);
    fracSum = SUM_W'(actFrac) + modExt;
    accSum  = SUM_W'(accQ) + fracSum;
    carryUp = (accSum >= HALF_S);
    carryDn = (accSum < -HALF_S);
    if (carryUp)      accWrap = accSum - FULL_S;
    else if (carryDn) accWrap = accSum + FULL_S;
    else              accWrap = accSum;
    base = RATIO_W'(actIdx) + RATIO_W'(BIAS);
    if (ctl.intMode)  ratioNext = base;
    else if (carryUp) ratioNext = base + RATIO_W'(1);
    else if (carryDn) ratioNext = base - RATIO_W'(1);
    else              ratioNext = base;
    fracCommit = ctl.narrow ? $signed({hiData, {LO_W{1'b0}}})
                            : $signed({hiData, shLo});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shIdx   <= '0;
      shLo    <= '0;
      actIdx  <= '0;
      actFrac <= '0;
      accQ    <= '0;
      ratioQ  <= '0;
    end else begin
      if (ctl.ldIdx) shIdx <= idxData;
      if (ctl.ldLo)  shLo  <= loData;
      if (ctl.commitInt) actIdx <= idxData;
      if (ctl.commitFrac) begin
        actIdx  <= shIdx;
        actFrac <= fracCommit;
      end
      if (ctl.step) ratioQ <= ratioNext;
      if (ctl.clearAcc || ctl.intMode) accQ <= '0;
      else if (ctl.step)               accQ <= accWrap[FRAC_W-1:0];
    end
  end

  assign ratio = ratioQ;

  // Assertions
  AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.step |=> $stable(ratio)); // R10

  AST_INT_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step && ctl.intMode |=> ratio == RATIO_W'($past(actIdx)) + RATIO_W'(BIAS)); // R2

  AST_DITHER_BAND: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step && !ctl.intMode |=>
      (ratio + RATIO_W'(1) >= $past(base)) && (ratio <= $past(base) + RATIO_W'(1))); // R11

  AST_SUM_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step && !ctl.intMode |-> (fracSum <= LIMIT_S) && (fracSum >= -LIMIT_S)); // R8

  AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clearAcc |=> accQ == '0); // R9

  AST_WIDE_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commitFrac && !ctl.narrow |=> actFrac[LO_W-1:0] == $past(shLo)); // R3

  AST_NARROW_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commitFrac && ctl.narrow |=> actFrac[LO_W-1:0] == '0); // R5

  AST_COMMIT_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commitFrac |=> actIdx == $past(shIdx)); // R4

endmodule

// File: rtl/fracn_seq.sv
module fracn_seq
  import fracn_seq_pkg::*;
#(
  parameter int IDX_W = 9,
  parameter int HI_W  = 10,
  parameter int LO_W  = 8,
  parameter int MOD_W = 12,
  parameter int BIAS  = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeInt,
  input  logic             modeWide,
  input  logic             idxWr,
  input  logic [IDX_W-1:0] idxData,
  input  logic             fracLoWr,
  input  logic [LO_W-1:0]  fracLoData,
  input  logic             fracHiWr,
  input  logic [HI_W-1:0]  fracHiData,
  input  logic [MOD_W-1:0] modOffset,
  input  logic             refStrobe,
  output logic [IDX_W:0]   ratio
);

  seqCtl_t ctl;

  fracn_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .modeInt   (modeInt),
    .modeWide  (modeWide),
    .idxWr     (idxWr),
    .fracLoWr  (fracLoWr),
    .fracHiWr  (fracHiWr),
    .refStrobe (refStrobe),
    .ctl       (ctl)
  );

  fracn_seq_dp #(
    .IDX_W (IDX_W),
    .HI_W  (HI_W),
    .LO_W  (LO_W),
    .MOD_W (MOD_W),
    .BIAS  (BIAS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .idxData   (idxData),
    .loData    (fracLoData),
    .hiData    (fracHiData),
    .modOffset (modOffset),
    .ratio     (ratio)
  );

endmodule

// File: tb/fracn_seq_bench.sv
module fracn_seq_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeInt = 1'b1;
  logic        modeWide = 1'b1;
  logic        idxWr = 1'b0;
  logic [8:0]  idxData = '0;
  logic        fracLoWr = 1'b0;
  logic [7:0]  fracLoData = '0;
  logic        fracHiWr = 1'b0;
  logic [9:0]  fracHiData = '0;
  logic [11:0] modOffset = '0;
  logic        refStrobe = 1'b0;
  logic [9:0]  ratio;

  int nTests = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fracn_seq u_fracn_seq (
    .clk(clk), .rstN(rstN), .modeInt(modeInt), .modeWide(modeWide),
    .idxWr(idxWr), .idxData(idxData), .fracLoWr(fracLoWr), .fracLoData(fracLoData),
    .fracHiWr(fracHiWr), .fracHiData(fracHiData), .modOffset(modOffset),
    .refStrobe(refStrobe), .ratio(ratio)
  );

  task automatic check(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wrIdx(input int v);
    @(negedge clk); idxWr = 1'b1; idxData = 9'(v);
    @(negedge clk); idxWr = 1'b0;
  endtask

  task automatic wrLo(input int v);
    @(negedge clk); fracLoWr = 1'b1; fracLoData = 8'(v);
    @(negedge clk); fracLoWr = 1'b0;
  endtask

  task automatic wrHi(input int v);
    @(negedge clk); fracHiWr = 1'b1; fracHiData = 10'(v);
    @(negedge clk); fracHiWr = 1'b0;
  endtask

  task automatic stepOne(output int r);
    @(negedge clk); refStrobe = 1'b1;
    @(negedge clk); refStrobe = 1'b0;
    r = int'(ratio);
  endtask

  task automatic stepSum(input int n, output int sum, output int lo, output int hi);
    int r;
    sum = 0; lo = 100000; hi = -1;
    for (int i = 0; i < n; i++) begin
      stepOne(r);
      sum += r;
      if (r < lo) lo = r;
      if (r > hi) hi = r;
    end
  endtask

  // toggle the width mode out and back: two mode changes, accumulator cleared
  task automatic clearAcc();
    @(negedge clk); modeWide = ~modeWide;
    @(negedge clk); modeWide = ~modeWide;
    @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 ratio after reset", int'(ratio), 0);
  endtask

  task automatic testInteger();
    int r;
    modeInt = 1'b1;
    wrIdx(18);
    repeat (3) @(negedge clk);
    check("R10 no change without strobe", int'(ratio), 0);
    stepOne(r); check("R2 index 18", r, 50);
    stepOne(r); check("R2 index 18 repeat", r, 50);
    wrLo(0); wrHi(10'h100);
    stepOne(r); check("R2 dividend ignored", r, 50);
    stepOne(r); check("R2 dividend ignored no dither", r, 50);
    wrIdx(0);   stepOne(r); check("R2 index 0", r, 32);
    wrIdx(511); stepOne(r); check("R2 index 511", r, 543);
    repeat (4) @(negedge clk);
    check("R10 held between strobes", int'(ratio), 543);
  endtask

  task automatic testWide();
    int r, s, lo, hi;
    modeInt = 1'b0; modeWide = 1'b1;
    @(negedge clk);
    wrIdx(42); wrLo(0);
    stepOne(r); check("R4 staged index not live", r, 543);
    wrHi(10'h100);   // +65536 = +0.25
    clearAcc();
    stepOne(r); check("R6 +0.25 step1", r, 74);
    stepOne(r); check("R6 +0.25 step2 carry", r, 75);
    stepOne(r); check("R6 +0.25 step3", r, 74);
    stepOne(r); check("R6 +0.25 step4", r, 74);
    wrLo(0); wrHi(10'h300);   // -65536 = -0.25
    clearAcc();
    stepOne(r); check("R6 -0.25 step1", r, 74);
    stepOne(r); check("R6 -0.25 step2", r, 74);
    stepOne(r); check("R6 -0.25 step3 borrow", r, 73);
    stepOne(r); check("R6 -0.25 step4", r, 74);
    wrLo(8'hCC); wrHi(10'h305);   // -64052
    clearAcc();
    stepSum(8, s, lo, hi);
    check("R3 wide dividend -64052 sum of 8", s, 590);
    check("R11 wide min", lo, 73);
    check("R11 wide max", hi, 74);
  endtask

  task automatic testNarrow();
    int r, s, lo, hi;
    modeWide = 1'b0;
    @(negedge clk);
    wrLo(8'hFF); wrIdx(36);
    stepOne(r); check("R4 narrow staged index not live", r, 74);
    wrHi(10'h100);   // +256/1024 = +0.25
    clearAcc();
    stepOne(r); check("R5 narrow +0.25 step1", r, 68);
    stepOne(r); check("R5 narrow +0.25 step2 carry", r, 69);
    stepOne(r); check("R5 narrow +0.25 step3", r, 68);
    stepOne(r); check("R5 narrow +0.25 step4", r, 68);
    wrHi(10'h3BA);   // -70
    clearAcc();
    stepSum(16, s, lo, hi);
    check("R5 narrow -70 sum of 16", s, 1087);
  endtask

  task automatic testModulation();
    int r, s, lo, hi;
    modeWide = 1'b0;
    wrIdx(36); wrHi(0);
    modOffset = 12'd256;     // +0.25 narrow
    clearAcc();
    stepOne(r); check("R7 offset step1", r, 68);
    stepOne(r); check("R7 offset step2 carry", r, 69);
    stepOne(r); check("R7 offset step3", r, 68);
    wrHi(10'd511);
    modOffset = 12'd65;      // total 576/1024 = 0.5625
    clearAcc();
    stepSum(16, s, lo, hi);
    check("R8 +0.5625 sum of 16", s, 1097);
    check("R11 max within band", hi, 69);
    check("R11 min within band", lo, 68);
    modOffset = '0;
  endtask

  task automatic testClear();
    int r;
    modeWide = 1'b1;
    wrIdx(42); wrLo(0); wrHi(10'h100);
    clearAcc();
    stepOne(r); check("R9 prefill step", r, 74);
    clearAcc();
    stepOne(r); check("R9 after clear step1", r, 74);
    stepOne(r); check("R9 after clear step2", r, 75);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testInteger();
    testWide();
    testNarrow();
    testModulation();
    testClear();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

endmodule